// File: doc/BRIEF.md
# Heater Setpoint DAC Refresh Controller

This block keeps a temperature-control setpoint DAC loaded over a write-only serial link. A host gives it short commands on a small command port: load a new setpoint, turn the heater on, turn it off, or ask for status. When the setpoint or the on/off state changes, the block sends one 24-bit frame to the DAC. It also resends the current content on a fixed period, so a DAC that lost its configuration gets the right value back within one period.

The serial clock is derived from the system clock. Its high and low phases are stretched so that the clock never runs faster than a set maximum rate. If a change arrives while a frame is already on the wire, the block sends it as soon as that frame ends, and the newest value wins. When the heater is off, the block sends a power-down code in place of the setpoint, both for demanded writes and for periodic writes.

Top module: `heat_dac_refresh`

## Requirements
- R1: After reset, `dac_sync_n` and `dac_sclk` are high, `stat_enabled`, `stat_value`, `stat_busy` and `stat_refresh_cnt` are zero, and the heater is off with a stored setpoint of zero.
- R2: Command codes on `cmd_op` are 0 for load setpoint (the setpoint is taken from `cmd_data`), 1 for heater on, 2 for heater off and 3 for status read. A command is taken in any cycle where `cmd_valid` is high.
- R3: A frame is 24 bits and is shifted out MSB first. Bits 23:22 hold the mode, bits 21:8 hold the value and bits 7:0 are zero. `dac_sync_n` stays low for the whole frame, and each bit is valid on the falling edge of `dac_sclk`.
- R4: Within a frame, every high phase and every low phase of `dac_sclk` lasts at least HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) system cycles, so the serial clock never exceeds SCLK_MAX_HZ.
- R5: A load with a value different from the stored setpoint produces one frame. A heater-on while off, or a heater-off while on, also produces one frame. A load of the same value, or a repeated on or off command, produces no frame.
- R6: With the heater on, a frame carries mode 00 and the stored setpoint. With the heater off, it carries mode PD_CODE (default 01) and a value of zero.
- R7: A periodic write is due in each cycle whose count since reset release is a multiple of REFRESH_CYCLES = CLK_HZ/REFRESH_HZ. The periodic write is sent even when nothing has changed.
- R8: A change that arrives during a frame is held. Exactly one further frame follows that frame, and it carries the state current when it starts.
- R9: A change and a periodic write that fall in the same cycle share a single frame, and that frame counts as a periodic write. A periodic write that falls during a frame is sent as its own frame after the frame in progress.
- R10: A status read raises `rsp_valid` for one cycle, one cycle later. `rsp_data` then holds the refresh count in bits 31:16, busy in bit 15, the on state in bit 14 and the last value sent in bits 13:0.
- R11: `stat_refresh_cnt` rises by exactly one when a frame that carried a periodic write completes, and changes at no other time. `stat_value` shows the value field of the last frame started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_data | input | 14 | Setpoint for the load command |
| rsp_valid | output | 1 | Status response strobe |
| rsp_data | output | 32 | Status response word |
| stat_enabled | output | 1 | Heater on state |
| stat_value | output | 14 | Value field of the last frame |
| stat_busy | output | 1 | Frame in progress or pending |
| stat_refresh_cnt | output | 16 | Completed periodic writes |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_sync_n | output | 1 | Frame select, active low |
| dac_mosi | output | 1 | Serial data to the DAC |

## Verification
A host change and the periodic timer can both call for a frame in the same cycle. The bench counts clock edges from reset release, so it can place a setpoint load in exactly the cycle in which the period expires. It then expects one frame with the new value and a refresh count raised by one, with no extra frame after it. A second case starts a demanded frame a few dozen cycles before the period expires, so the timer fires during the frame. That case must give two frames with the same content, in order.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
   typedef enum logic [1:0] {
      OP_LOAD    = 2'd0,
      OP_HEAT_ON = 2'd1,
      OP_HEAT_OFF= 2'd2,
      OP_STATUS  = 2'd3
   } hdr_op_e;

   function automatic int unsigned half_cycles(input longint unsigned clk_hz,
                                               input longint unsigned sclk_hz);
      return int'((clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz));
   endfunction
endpackage

// File: rtl/hdr_tick.sv
module hdr_tick #(
   parameter int unsigned PERIOD = 100
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("hdr_tick: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = (cnt == CW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hdr_spi_tx.sv
module hdr_spi_tx #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned HALF    = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               active,
   output logic               done,
   output logic               sclk,
   output logic               sync_n,
   output logic               mosi
);
   localparam int unsigned DIV_W = $clog2(HALF + 1);
   localparam int unsigned BIT_W = $clog2(FRAME_W);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("hdr_spi_tx: HALF must be at least 1");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("hdr_spi_tx: FRAME_W must be at least 2");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW, ST_GAP} st_e;

   st_e                st;
   logic [DIV_W-1:0]   div;
   logic [BIT_W-1:0]   bitn;
   logic [FRAME_W-1:0] sh;
   logic               div_end;

   assign div_end = (div == DIV_W'(HALF - 1));
   assign active  = (st != ST_IDLE);
   assign mosi    = sh[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         div    <= '0;
         bitn   <= '0;
         sh     <= '0;
         sclk   <= 1'b1;
         sync_n <= 1'b1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  sh     <= frame;
                  sync_n <= 1'b0;
                  div    <= '0;
                  bitn   <= '0;
                  st     <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (div_end) begin
                  div  <= '0;
                  sclk <= 1'b0;
                  st   <= ST_LOW;
               end else begin
                  div <= div + 1'b1;
               end
            end
            ST_LOW: begin
               if (div_end) begin
                  div  <= '0;
                  sclk <= 1'b1;
                  if (bitn == BIT_W'(FRAME_W - 1)) begin
                     sync_n <= 1'b1;
                     st     <= ST_GAP;
                  end else begin
                     bitn <= bitn + 1'b1;
                     sh   <= {sh[FRAME_W-2:0], 1'b0};
                     st   <= ST_HIGH;
                  end
               end else begin
                  div <= div + 1'b1;
               end
            end
            default: begin
               if (div_end) begin
                  div  <= '0;
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else begin
                  div <= div + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/hdr_regs.sv
module hdr_regs
   import hdr_pkg::*;
#(
   parameter int unsigned          VAL_W   = 14,
   parameter int unsigned          MODE_W  = 2,
   parameter int unsigned          PAD_W   = 8,
   parameter logic [MODE_W-1:0]    PD_CODE = 2'b01,
   parameter int unsigned          CNT_W   = 16,
   parameter bit                   CNT_SAT = 1'b0,
   localparam int unsigned         FRAME_W = MODE_W + VAL_W + PAD_W,
   localparam int unsigned         RSP_W   = CNT_W + 2 + VAL_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [VAL_W-1:0]   cmd_data,
   input  logic               tick,
   input  logic               spi_active,
   input  logic               spi_done,
   output logic               start,
   output logic [FRAME_W-1:0] frame,
   output logic               rsp_valid,
   output logic [RSP_W-1:0]   rsp_data,
   output logic               stat_enabled,
   output logic [VAL_W-1:0]   stat_value,
   output logic               stat_busy,
   output logic [CNT_W-1:0]   stat_refresh_cnt
);
   logic [VAL_W-1:0] setp;
   logic             heat_on;
   logic             pend_chg;
   logic             pend_per;
   logic             cur_per;
   logic             chg_ev;
   logic [VAL_W-1:0] val_field;
   logic [CNT_W-1:0] cnt_next;
   hdr_op_e          op;

   assign op = hdr_op_e'(cmd_op);

   always_comb begin
      chg_ev = 1'b0;
      if (cmd_valid) begin
         case (op)
            OP_LOAD:     chg_ev = (cmd_data != setp);
            OP_HEAT_ON:  chg_ev = !heat_on;
            OP_HEAT_OFF: chg_ev = heat_on;
            default:     chg_ev = 1'b0;
         endcase
      end
   end

   assign start     = !spi_active && (pend_chg || pend_per);
   assign val_field = heat_on ? setp : '0;
   assign frame     = {(heat_on ? MODE_W'(0) : PD_CODE), val_field, PAD_W'(0)};

   generate
      if (CNT_SAT) begin : g_cnt_sat
         assign cnt_next = (&stat_refresh_cnt) ? stat_refresh_cnt
                                               : stat_refresh_cnt + 1'b1;
      end else begin : g_cnt_wrap
         assign cnt_next = stat_refresh_cnt + 1'b1;
      end
   endgenerate

   assign stat_enabled = heat_on;
   assign stat_busy    = spi_active || pend_chg || pend_per;

   always_ff @(posedge clk) begin
      if (rst) begin
         setp             <= '0;
         heat_on          <= 1'b0;
         pend_chg         <= 1'b0;
         pend_per         <= 1'b0;
         cur_per          <= 1'b0;
         stat_value       <= '0;
         stat_refresh_cnt <= '0;
         rsp_valid        <= 1'b0;
         rsp_data         <= '0;
      end else begin
         if (cmd_valid && op == OP_LOAD)     setp    <= cmd_data;
         if (cmd_valid && op == OP_HEAT_ON)  heat_on <= 1'b1;
         if (cmd_valid && op == OP_HEAT_OFF) heat_on <= 1'b0;

         pend_chg <= (pend_chg && !start) || chg_ev;
         pend_per <= (pend_per && !start) || tick;

         if (start) begin
            cur_per    <= pend_per;
            stat_value <= val_field;
         end
         if (spi_done && cur_per) stat_refresh_cnt <= cnt_next;

         rsp_valid <= cmd_valid && (op == OP_STATUS);
         if (cmd_valid && op == OP_STATUS)
            rsp_data <= {stat_refresh_cnt, stat_busy, heat_on, stat_value};
      end
   end
endmodule

// File: rtl/heat_dac_refresh.sv
module heat_dac_refresh #(
   parameter longint unsigned   CLK_HZ      = 100_000_000,
   parameter longint unsigned   SCLK_MAX_HZ = 1_000_000,
   parameter longint unsigned   REFRESH_HZ  = 1,
   parameter int unsigned       VAL_W       = 14,
   parameter int unsigned       MODE_W      = 2,
   parameter int unsigned       PAD_W       = 8,
   parameter logic [MODE_W-1:0] PD_CODE     = 2'b01,
   parameter int unsigned       CNT_W       = 16,
   parameter bit                CNT_SAT     = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cmd_valid,
   input  logic [1:0]                 cmd_op,
   input  logic [VAL_W-1:0]           cmd_data,
   output logic                       rsp_valid,
   output logic [CNT_W+2+VAL_W-1:0]   rsp_data,
   output logic                       stat_enabled,
   output logic [VAL_W-1:0]           stat_value,
   output logic                       stat_busy,
   output logic [CNT_W-1:0]           stat_refresh_cnt,
   output logic                       dac_sclk,
   output logic                       dac_sync_n,
   output logic                       dac_mosi
);
   localparam int unsigned FRAME_W        = MODE_W + VAL_W + PAD_W;
   localparam int unsigned HALF           = hdr_pkg::half_cycles(CLK_HZ, SCLK_MAX_HZ);
   localparam int unsigned REFRESH_CYCLES = int'(CLK_HZ / REFRESH_HZ);
   localparam int unsigned FRAME_CYCLES   = (2 * FRAME_W + 1) * HALF + 1;

   generate
      if (SCLK_MAX_HZ == 0 || REFRESH_HZ == 0) begin : g_bad_rate
         $error("heat_dac_refresh: rates must be non-zero");
      end
      if (REFRESH_CYCLES <= FRAME_CYCLES) begin : g_bad_period
         $error("heat_dac_refresh: refresh period shorter than one frame");
      end
   endgenerate

   logic               tick;
   logic               start;
   logic               spi_active;
   logic               spi_done;
   logic [FRAME_W-1:0] frame;

   hdr_tick #(.PERIOD(REFRESH_CYCLES)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   hdr_regs #(
      .VAL_W   (VAL_W),
      .MODE_W  (MODE_W),
      .PAD_W   (PAD_W),
      .PD_CODE (PD_CODE),
      .CNT_W   (CNT_W),
      .CNT_SAT (CNT_SAT)
   ) u_regs (
      .clk              (clk),
      .rst              (rst),
      .cmd_valid        (cmd_valid),
      .cmd_op           (cmd_op),
      .cmd_data         (cmd_data),
      .tick             (tick),
      .spi_active       (spi_active),
      .spi_done         (spi_done),
      .start            (start),
      .frame            (frame),
      .rsp_valid        (rsp_valid),
      .rsp_data         (rsp_data),
      .stat_enabled     (stat_enabled),
      .stat_value       (stat_value),
      .stat_busy        (stat_busy),
      .stat_refresh_cnt (stat_refresh_cnt)
   );

   hdr_spi_tx #(.FRAME_W(FRAME_W), .HALF(HALF)) u_spi (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .frame  (frame),
      .active (spi_active),
      .done   (spi_done),
      .sclk   (dac_sclk),
      .sync_n (dac_sync_n),
      .mosi   (dac_mosi)
   );
endmodule

// File: rtl/hdr_chk.sv
module hdr_chk #(
   parameter int unsigned HALF  = 4,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic             rsp_valid,
   input logic             stat_busy,
   input logic [CNT_W-1:0] stat_refresh_cnt,
   input logic             dac_sclk,
   input logic             dac_sync_n,
   input logic             dac_mosi
);
   logic             prev_sclk;
   logic             prev_status;
   logic [CNT_W-1:0] prev_cnt;
   logic [31:0]      hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_sclk   <= 1'b1;
         prev_status <= 1'b0;
         prev_cnt    <= '0;
         hold        <= HALF;
      end else begin
         prev_sclk   <= dac_sclk;
         prev_status <= cmd_valid && (cmd_op == 2'd3);
         prev_cnt    <= stat_refresh_cnt;
         hold        <= (dac_sclk != prev_sclk) ? 32'd1 : hold + 1;
      end
   end

   // R4
   sclk_width_chk: assert property (@(posedge clk) disable iff (rst)
      (dac_sclk != prev_sclk) |-> (hold >= HALF));

   // R3
   sclk_fall_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dac_sclk) |-> !dac_sync_n);

   // R3
   mosi_stable_low_chk: assert property (@(posedge clk) disable iff (rst)
      (!dac_sync_n && !dac_sclk && !prev_sclk) |-> $stable(dac_mosi));

   // R8
   idle_sync_high_chk: assert property (@(posedge clk) disable iff (rst)
      !stat_busy |-> dac_sync_n);

   // R10
   rsp_after_status_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> prev_status);

   // R11
   refresh_step_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_refresh_cnt != prev_cnt) |-> (stat_refresh_cnt == prev_cnt + 1'b1));
endmodule

bind heat_dac_refresh hdr_chk #(.HALF(HALF), .CNT_W(CNT_W)) u_chk (
   .clk              (clk),
   .rst              (rst),
   .cmd_valid        (cmd_valid),
   .cmd_op           (cmd_op),
   .rsp_valid        (rsp_valid),
   .stat_busy        (stat_busy),
   .stat_refresh_cnt (stat_refresh_cnt),
   .dac_sclk         (dac_sclk),
   .dac_sync_n       (dac_sync_n),
   .dac_mosi         (dac_mosi)
);

// File: tb/sim_heat_dac_refresh.sv
`timescale 1ns/1ps
module sim_heat_dac_refresh;
   localparam int RC   = 4000;
   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [13:0] cmd_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        stat_enabled;
   logic [13:0] stat_value;
   logic        stat_busy;
   logic [15:0] stat_refresh_cnt;
   logic        dac_sclk, dac_sync_n, dac_mosi;

   heat_dac_refresh #(
      .CLK_HZ(8_000_000), .SCLK_MAX_HZ(1_000_000), .REFRESH_HZ(2000)
   ) u0 (.*);

   always #2.5 clk = ~clk;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          edge_cnt = 0;
   bit          finished = 0;
   logic [23:0] exp_q[$];

   always @(posedge clk) if (!rst) edge_cnt <= edge_cnt + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_cmd(input logic [1:0] op, input logic [13:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (stat_busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: decodes frames and checks clock phase widths
   logic        p_sclk = 1'b1, p_sync = 1'b1;
   int          run = HALF, nbits = 0;
   logic [23:0] sh = '0;
   always @(negedge clk) begin
      if (!rst) begin
         if (dac_sclk != p_sclk) begin
            if (!p_sync)
               chk(run >= HALF, "R4 sclk phase", run, HALF);
            run = 1;
         end else run++;
         if (p_sync && !dac_sync_n) begin nbits = 0; sh = '0; end
         if (!dac_sync_n && p_sclk && !dac_sclk) begin
            sh = {sh[22:0], dac_mosi}; nbits++;
         end
         if (!p_sync && dac_sync_n) begin
            chk(nbits == 24, "R3 bit count", nbits, 24);
            if (exp_q.size() == 0)
               chk(1'b0, "R5 unexpected frame", {8'h0, sh}, 32'h0);
            else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(sh == e, "R3/R6 frame", {8'h0, sh}, {8'h0, e});
            end
         end
         p_sclk = dac_sclk; p_sync = dac_sync_n;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(dac_sync_n && dac_sclk, "R1 pins", {dac_sync_n, dac_sclk}, 2'b11);
      chk({stat_enabled, stat_value, stat_busy, stat_refresh_cnt} == '0, "R1 status",
          {stat_enabled, stat_value, stat_busy, stat_refresh_cnt}, 0);

      // R2 R6: load while off sends power-down frame
      exp_q.push_back(24'h400000);
      send_cmd(2'd0, 14'h1234);
      wait_idle();
      chk(stat_value == 14'h0, "R6 value off", stat_value, 0);
      // R5: same value, no frame
      send_cmd(2'd0, 14'h1234);
      repeat (300) @(negedge clk);
      chk(!stat_busy && exp_q.size() == 0, "R5 same load idle", stat_busy, 0);

      // R6 on with setpoint; R8 two loads during frame give one frame
      exp_q.push_back(24'h123400);
      send_cmd(2'd1, 14'h0);
      repeat (20) @(negedge clk);
      exp_q.push_back(24'h0ABD00);
      send_cmd(2'd0, 14'h0ABC);
      send_cmd(2'd0, 14'h0ABD);
      wait_idle();
      chk(stat_enabled, "R2 heater on", stat_enabled, 1);
      // R10 status read
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(rsp_valid, "R10 rsp_valid", rsp_valid, 1);
      chk(rsp_data == {16'd0, 1'b0, 1'b1, 14'h0ABD}, "R10 rsp_data", rsp_data,
          {16'd0, 1'b0, 1'b1, 14'h0ABD});
      @(negedge clk);
      chk(!rsp_valid, "R10 one cycle", rsp_valid, 0);
      // R5 repeated enable
      send_cmd(2'd1, 14'h0);
      repeat (300) @(negedge clk);
      chk(!stat_busy && exp_q.size() == 0, "R5 repeat on idle", stat_busy, 0);

      // R7 periodic write with nothing changed
      exp_q.push_back(24'h0ABD00);
      wait (edge_cnt == RC + 2);
      wait_idle();
      chk(stat_refresh_cnt == 16'd1, "R7 R11 count", stat_refresh_cnt, 1);

      // R9 load in the very cycle the period expires
      exp_q.push_back(24'h200100);
      wait (edge_cnt == 2 * RC - 1);
      send_cmd(2'd0, 14'h2001);
      wait_idle();
      repeat (300) @(negedge clk);
      chk(stat_refresh_cnt == 16'd2, "R9 shared frame count", stat_refresh_cnt, 2);
      chk(stat_value == 14'h2001, "R11 value", stat_value, 14'h2001);
      chk(exp_q.size() == 0, "R9 no extra", exp_q.size(), 0);

      // R6 off, then periodic write while off
      exp_q.push_back(24'h400000);
      send_cmd(2'd2, 14'h0);
      wait_idle();
      exp_q.push_back(24'h400000);
      wait (edge_cnt == 3 * RC + 2);
      wait_idle();
      chk(stat_refresh_cnt == 16'd3, "R7 off count", stat_refresh_cnt, 3);
      chk(stat_value == 14'h0, "R6 off value", stat_value, 0);

      // R9 period expires during a demanded frame
      exp_q.push_back(24'h200100);
      exp_q.push_back(24'h200100);
      wait (edge_cnt == 4 * RC - 61);
      send_cmd(2'd1, 14'h0);
      wait_idle();
      repeat (100) @(negedge clk);
      chk(stat_refresh_cnt == 16'd4, "R9 R11 count", stat_refresh_cnt, 4);
      chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
      finish_run();
   end
endmodule